// File: doc/BRIEF.md
# Drift-Compensated Nanosecond Time Counter

This block keeps a 64-bit time of day in nanoseconds. Each clock cycle it adds a 32-bit addend to a phase accumulator. When that sum carries out, the counter moves forward by a programmable reference period. Software trims the clock rate by changing the addend. A bypass mode instead steps the counter by the period on every enabled cycle.

A 32-bit register port gives access to the following:
- control word;
- both halves of the counter;
- addend and accumulator;
- output-clock prescaler;
- two 64-bit alarm comparators;
- two periods for the fixed-interval pulse generators.

When the counter reaches an alarm value, the block raises a one-cycle strobe and drives a polarity-selectable alarm pin. The pulse generators emit one-cycle strobes at their programmed intervals. An event unit outside the block uses these strobes. By default, alarm 0 re-phases the pulse generators, so software can line them up with a second boundary. The prescaler divides counter steps down to a slow output clock.

Top module: `tod_timer`

## Requirements
- R1: After synchronous reset, every register reads 0, `time_ns` is 0, and all strobes, alarm pins and `clk_out` are 0.
- R2: While the enable bit (control bit 2) is 0, the counter and the accumulator hold their values unless the bus writes them.
- R3: On each enabled cycle with bypass off, the accumulator becomes accumulator + addend mod 2^32. Each carry out of that add adds the period field (control bits 25:16) to the counter.
- R4: With bypass (control bit 3) set, the counter adds the period field on every enabled cycle and the accumulator holds.
- R5: A write to count-low (address 1) is only staged and leaves the counter unchanged. A write to count-high (address 2) loads {high, staged low} at once. If a counter step falls in the same cycle, the write wins and that step is lost.
- R6: Read data appears on `bus_rdata` in the cycle after `bus_rd`. Reading count-low captures the current high word into a shadow register, and reading count-high returns that shadow.
- R7: When the enabled counter first equals an alarm value, the matching `alarm_evt` bit is high for exactly one cycle: the cycle after the match. Alarm 0 is at addresses 6 (low) and 7 (high); alarm 1 is at addresses 8 and 9.
- R8: Each `alarm_out` bit equals its strobe, inverted when its polarity bit is 1. Polarity is control bit 31 for alarm 0 and bit 30 for alarm 1. A polarity change reaches the pin within two cycles.
- R9: Once running, pulse generator k (period at address 10 + k, in ns) pulses `pulse_evt[k]` on the counter step at which its programmed interval has elapsed.
- R10: With realignment allowed (control bit 14 = 0), no pulse occurs before the first alarm-0 hit. That hit restarts both generators with a full period, so generator k first pulses when `time_ns` = alarm 0 + step + period k. It also sets the started flag (control bit 28, read-only).
- R11: With control bit 14 = 1, the generators start with the first enabled cycle, in phase with the counter, and an alarm-0 hit leaves their phase alone.
- R12: Writing control with bit 5 set clears the counter, accumulator, started flag, generators and prescaler. Bit 5 always reads 0.
- R13: `clk_out` toggles once every P counter steps, where P is the 16-bit prescale value at address 5. A value of 0 acts as 1.
- R14: Registers at addresses 3, 5 and 6 to 11 read back what was written. Control reads back its stored fields: bits 31, 30, 28, 25:16, 14, 3, 2 and 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_rd` |
| time_ns | output | 64 | Current counter value |
| alarm_evt | output | 2 | One-cycle alarm strobes |
| alarm_out | output | 2 | Alarm pins after polarity |
| pulse_evt | output | 2 | Fixed-interval pulse strobes |
| clk_out | output | 1 | Prescaled output clock |

## Verification
A bus commit of the counter can fall in the same cycle as an automatic counter step. In bypass mode there is a step on every enabled cycle. The bench writes count-high while the counter is running, and expects the final value to be the written value plus only the steps taken after the commit. The bench also lets the alarm-0 hit land while generators are idle or already running, and judges the first pulse times for each case.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int ADDR_W = 4;
  localparam int N_ALM  = 2;
  localparam int N_PG   = 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL    = 4'd0,
    RA_CNT_LO  = 4'd1,
    RA_CNT_HI  = 4'd2,
    RA_ADDEND  = 4'd3,
    RA_ACCUM   = 4'd4,
    RA_PRSC    = 4'd5,
    RA_ALM0_LO = 4'd6,
    RA_ALM0_HI = 4'd7,
    RA_ALM1_LO = 4'd8,
    RA_ALM1_HI = 4'd9,
    RA_PPD0    = 4'd10,
    RA_PPD1    = 4'd11
  } reg_addr_e;

  // control word bit positions
  localparam int B_EN      = 2;
  localparam int B_BYP     = 3;
  localparam int B_SRST    = 5;
  localparam int B_NOALIGN = 14;
  localparam int B_PER     = 16;
  localparam int B_STARTED = 28;
  localparam int B_POL1    = 30;
  localparam int B_POL0    = 31;
endpackage

// File: rtl/tod_step.sv
module tod_step #(
  parameter int CNT_W = 64,
  parameter int ACC_W = 32,
  parameter int PER_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             byp,
  input  logic [ACC_W-1:0] addend,
  input  logic [PER_W-1:0] period,
  input  logic             acc_wr,
  input  logic [ACC_W-1:0] acc_wdata,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [ACC_W-1:0] acc_q,
  output logic             tick
);
  logic [ACC_W:0] sum;

  assign sum  = {1'b0, acc_q} + {1'b0, addend};
  assign tick = en & (byp | sum[ACC_W]);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else begin
      if (acc_wr)          acc_q <= acc_wdata;
      else if (en && !byp) acc_q <= sum[ACC_W-1:0];
      if (cnt_wr)          cnt_q <= cnt_wdata;
      else if (tick)       cnt_q <= cnt_q + CNT_W'(period);
    end
  end
endmodule

// File: rtl/tod_alarm.sv
module tod_alarm #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             pol,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] target,
  output logic             hit,
  output logic             evt,
  output logic             pin
);
  logic match, match_d;

  assign match = en && (cnt == target);
  assign hit   = match && !match_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      match_d <= 1'b0;
      evt     <= 1'b0;
      pin     <= 1'b0;
    end else begin
      match_d <= match;
      evt     <= hit;
      pin     <= hit ^ pol;
    end
  end
endmodule

// File: rtl/tod_pulse.sv
module tod_pulse #(
  parameter int PPD_W = 32,
  parameter int PER_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic             restart,
  input  logic             tick,
  input  logic [PER_W-1:0] step,
  input  logic [PPD_W-1:0] ppd,
  output logic             evt
);
  logic [PPD_W-1:0] rem;
  logic [PPD_W-1:0] step_w;

  assign step_w = PPD_W'(step);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rem <= '0;
      evt <= 1'b0;
    end else begin
      evt <= 1'b0;
      if (restart || !run) begin
        rem <= ppd;
      end else if (tick) begin
        if (rem <= step_w) begin
          evt <= 1'b1;
          rem <= ppd;
        end else begin
          rem <= rem - step_w;
        end
      end
    end
  end
endmodule

// File: rtl/tod_timer.sv
module tod_timer
  import tod_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int PER_W  = 10,
  parameter int PRSC_W = 16,
  parameter int PPD_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BUS_W-1:0]     bus_wdata,
  output logic [BUS_W-1:0]     bus_rdata,
  output logic [2*BUS_W-1:0]   time_ns,
  output logic [N_ALM-1:0]     alarm_evt,
  output logic [N_ALM-1:0]     alarm_out,
  output logic [N_PG-1:0]      pulse_evt,
  output logic                 clk_out
);
  localparam int CNT_W = 2 * BUS_W;

  logic                          en_q, byp_q, noalign_q, started;
  logic [1:0]                    csel_q;
  logic [N_ALM-1:0]              pol_q;
  logic [PER_W-1:0]              per_q;
  logic [BUS_W-1:0]              addend_q, lo_stage, hi_shadow;
  logic [PRSC_W-1:0]             prsc_q, div_cnt;
  logic [N_ALM-1:0][CNT_W-1:0]   alm_q;
  logic [N_PG-1:0][PPD_W-1:0]    ppd_q;
  logic [N_ALM-1:0]              alm_hit;
  logic [CNT_W-1:0]              cnt_q;
  logic [BUS_W-1:0]              acc_q;
  logic                          tick;
  logic                          wr_ctrl, srst_wr, cnt_wr, acc_wr;
  logic                          start_now, realign, pg_run;
  logic [BUS_W-1:0]              ctrl_word;

  assign wr_ctrl   = bus_wr && (bus_addr == RA_CTRL);
  assign srst_wr   = wr_ctrl && bus_wdata[B_SRST];
  assign cnt_wr    = bus_wr && (bus_addr == RA_CNT_HI);
  assign acc_wr    = bus_wr && (bus_addr == RA_ACCUM);
  assign realign   = alm_hit[0] && !noalign_q;
  assign start_now = en_q && noalign_q;
  assign pg_run    = started || start_now;
  assign time_ns   = cnt_q;

  // control fields
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      byp_q     <= 1'b0;
      noalign_q <= 1'b0;
      csel_q    <= '0;
      pol_q     <= '0;
      per_q     <= '0;
    end else if (wr_ctrl) begin
      en_q      <= bus_wdata[B_EN];
      byp_q     <= bus_wdata[B_BYP];
      noalign_q <= bus_wdata[B_NOALIGN];
      csel_q    <= bus_wdata[1:0];
      pol_q[0]  <= bus_wdata[B_POL0];
      pol_q[1]  <= bus_wdata[B_POL1];
      per_q     <= bus_wdata[B_PER +: PER_W];
    end
  end

  // plain data registers
  always_ff @(posedge clk) begin
    if (rst) begin
      addend_q <= '0;
      prsc_q   <= '0;
      lo_stage <= '0;
    end else if (bus_wr) begin
      if (bus_addr == RA_ADDEND) addend_q <= bus_wdata;
      if (bus_addr == RA_PRSC)   prsc_q   <= bus_wdata[PRSC_W-1:0];
      if (bus_addr == RA_CNT_LO) lo_stage <= bus_wdata;
    end
  end

  // started flag: set by first realignment or by a free-running start
  always_ff @(posedge clk) begin
    if (rst || srst_wr)           started <= 1'b0;
    else if (start_now || realign) started <= 1'b1;
  end

  tod_step #(.CNT_W(CNT_W), .ACC_W(BUS_W), .PER_W(PER_W)) u_step (
    .clk(clk), .rst(rst), .clr(srst_wr), .en(en_q), .byp(byp_q),
    .addend(addend_q), .period(per_q),
    .acc_wr(acc_wr), .acc_wdata(bus_wdata),
    .cnt_wr(cnt_wr), .cnt_wdata({bus_wdata, lo_stage}),
    .cnt_q(cnt_q), .acc_q(acc_q), .tick(tick)
  );

  for (genvar g = 0; g < N_ALM; g++) begin : g_alm
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(RA_ALM0_LO) + ADDR_W'(2 * g);
    localparam logic [ADDR_W-1:0] A_HI = A_LO + ADDR_W'(1);

    always_ff @(posedge clk) begin
      if (rst) begin
        alm_q[g] <= '0;
      end else if (bus_wr) begin
        if (bus_addr == A_LO) alm_q[g][BUS_W-1:0]     <= bus_wdata;
        if (bus_addr == A_HI) alm_q[g][CNT_W-1:BUS_W] <= bus_wdata;
      end
    end

    tod_alarm #(.CNT_W(CNT_W)) u_alarm (
      .clk(clk), .rst(rst), .en(en_q), .pol(pol_q[g]),
      .cnt(cnt_q), .target(alm_q[g]),
      .hit(alm_hit[g]), .evt(alarm_evt[g]), .pin(alarm_out[g])
    );
  end

  for (genvar k = 0; k < N_PG; k++) begin : g_pg
    localparam logic [ADDR_W-1:0] A_PD = ADDR_W'(RA_PPD0) + ADDR_W'(k);

    always_ff @(posedge clk) begin
      if (rst)                             ppd_q[k] <= '0;
      else if (bus_wr && bus_addr == A_PD) ppd_q[k] <= PPD_W'(bus_wdata);
    end

    tod_pulse #(.PPD_W(PPD_W), .PER_W(PER_W)) u_pulse (
      .clk(clk), .rst(rst), .clr(srst_wr), .run(pg_run), .restart(realign),
      .tick(tick), .step(per_q), .ppd(ppd_q[k]), .evt(pulse_evt[k])
    );
  end

  // prescaled output clock
  always_ff @(posedge clk) begin
    if (rst || srst_wr) begin
      div_cnt <= '0;
      clk_out <= 1'b0;
    end else if (tick) begin
      if (({1'b0, div_cnt} + 1'b1) >= {1'b0, prsc_q}) begin
        div_cnt <= '0;
        clk_out <= ~clk_out;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    ctrl_word                   = '0;
    ctrl_word[B_POL0]           = pol_q[0];
    ctrl_word[B_POL1]           = pol_q[1];
    ctrl_word[B_STARTED]        = started;
    ctrl_word[B_PER +: PER_W]   = per_q;
    ctrl_word[B_NOALIGN]        = noalign_q;
    ctrl_word[B_BYP]            = byp_q;
    ctrl_word[B_EN]             = en_q;
    ctrl_word[1:0]              = csel_q;
  end

  // registered read port with coherent high-word shadow
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      hi_shadow <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        RA_CTRL:    bus_rdata <= ctrl_word;
        RA_CNT_LO:  begin
                      bus_rdata <= cnt_q[BUS_W-1:0];
                      hi_shadow <= cnt_q[CNT_W-1:BUS_W];
                    end
        RA_CNT_HI:  bus_rdata <= hi_shadow;
        RA_ADDEND:  bus_rdata <= addend_q;
        RA_ACCUM:   bus_rdata <= acc_q;
        RA_PRSC:    bus_rdata <= BUS_W'(prsc_q);
        RA_ALM0_LO: bus_rdata <= alm_q[0][BUS_W-1:0];
        RA_ALM0_HI: bus_rdata <= alm_q[0][CNT_W-1:BUS_W];
        RA_ALM1_LO: bus_rdata <= alm_q[1][BUS_W-1:0];
        RA_ALM1_HI: bus_rdata <= alm_q[1][CNT_W-1:BUS_W];
        RA_PPD0:    bus_rdata <= BUS_W'(ppd_q[0]);
        RA_PPD1:    bus_rdata <= BUS_W'(ppd_q[1]);
        default:    bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tod_timer_chk.sv
module tod_timer_chk #(
  parameter int CNT_W = 64,
  parameter int BUS_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_wr,
  input logic             en_q,
  input logic             byp_q,
  input logic             started,
  input logic [CNT_W-1:0] time_ns,
  input logic [BUS_W-1:0] acc_q,
  input logic [1:0]       alarm_evt,
  input logic [1:0]       pulse_evt
);
  // R2: disabled and untouched by the bus -> time and phase hold
  a_r2_freeze: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !bus_wr) |=> ($stable(time_ns) && $stable(acc_q)));

  // R4: bypass stepping leaves the accumulator alone
  a_r4_bypass_hold: assert property (@(posedge clk) disable iff (rst)
    (en_q && byp_q && !bus_wr) |=> $stable(acc_q));

  // R7: alarm strobes last one cycle
  a_r7_alarm0_single: assert property (@(posedge clk) disable iff (rst)
    alarm_evt[0] |=> !alarm_evt[0]);
  a_r7_alarm1_single: assert property (@(posedge clk) disable iff (rst)
    alarm_evt[1] |=> !alarm_evt[1]);

  // R7: a strobe needs the timer enabled in the cycle before
  a_r7_alarm_needs_en: assert property (@(posedge clk) disable iff (rst)
    (|alarm_evt) |-> $past(en_q));

  // R10: no pulse before the generators have started
  a_r10_pulse_after_start: assert property (@(posedge clk) disable iff (rst)
    (|pulse_evt) |-> started);

  // R12: only a control write can drop the started flag
  a_r12_started_sticky: assert property (@(posedge clk) disable iff (rst)
    (started && !bus_wr) |=> started);
endmodule

bind tod_timer tod_timer_chk #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .en_q(en_q), .byp_q(byp_q),
  .started(started), .time_ns(time_ns), .acc_q(acc_q),
  .alarm_evt(alarm_evt), .pulse_evt(pulse_evt)
);

// File: tb/tod_timer_bench.sv
module tod_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] time_ns;
  logic [1:0]  alarm_evt, alarm_out, pulse_evt;
  logic        clk_out;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  localparam logic [31:0] EN = 32'h4, BYP = 32'h8, SRST = 32'h20, NOAL = 32'h4000;
  localparam logic [31:0] PER10 = 32'd10 << 16, PER8 = 32'd8 << 16;

  tod_timer u_tod_timer (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .time_ns(time_ns),
    .alarm_evt(alarm_evt), .alarm_out(alarm_out), .pulse_evt(pulse_evt),
    .clk_out(clk_out)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard for reads
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(bus_rdata == e, t, bus_rdata, e);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // event monitor
  logic [63:0] a0_t, a1_t;
  logic [63:0] p_first[2], p_last[2];
  int          p_n[2];
  int          a0_n, pre_n, tog_n;
  logic        a0_out, co_prev = 1'b0;

  task automatic clear_mon();
    a0_t = '0; a1_t = '0; a0_n = 0; pre_n = 0; a0_out = 1'b0;
    for (int i = 0; i < 2; i++) begin p_first[i] = '0; p_last[i] = '0; p_n[i] = 0; end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < 2; i++) begin
        if (pulse_evt[i]) begin
          if (p_n[i] == 0) p_first[i] = time_ns;
          p_last[i] = time_ns;
          p_n[i]++;
          if (a0_n == 0) pre_n++;
        end
      end
      if (alarm_evt[0]) begin a0_t = time_ns; a0_n++; a0_out = alarm_out[0]; end
      if (alarm_evt[1]) a1_t = time_ns;
      if (clk_out != co_prev) tog_n++;
      co_prev = clk_out;
    end
  end

  initial begin
    #(4 * 100000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    clear_mon();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(time_ns == 0, "R1 time", time_ns, 0);
    chk(alarm_evt == 0 && pulse_evt == 0, "R1 strobes", {alarm_evt, pulse_evt}, 0);
    chk(alarm_out == 0 && clk_out == 0, "R1 pins", {alarm_out, clk_out}, 0);
    rd(4'd0, 32'h0, "R1 ctrl");
    rd(4'd3, 32'h0, "R1 addend");
    rd(4'd1, 32'h0, "R1 cnt_lo");

    // R5 staging, R6 shadow
    wr(4'd1, 32'h89AB_CDEF);
    rd(4'd1, 32'h0, "R5 low write staged only");
    wr(4'd2, 32'h0123_4567);
    rd(4'd1, 32'h89AB_CDEF, "R5 commit low");
    wr(4'd1, 32'h0);
    wr(4'd2, 32'h9);
    rd(4'd2, 32'h0123_4567, "R6 shadow high");
    rd(4'd1, 32'h0, "R6 new low");
    rd(4'd2, 32'h9, "R6 new high");
    chk(time_ns == 64'h9_0000_0000, "R5 time after commit", time_ns, 64'h9_0000_0000);

    // R12 soft reset, R3 addend stepping, R2 freeze
    wr(4'd0, SRST);
    chk(time_ns == 0, "R12 counter cleared", time_ns, 0);
    rd(4'd0, 32'h0, "R12 srst reads 0");
    wr(4'd3, 32'h6000_0000);
    wr(4'd0, EN | PER8);
    repeat (9) @(negedge clk);
    wr(4'd0, PER8);
    chk(time_ns == 24, "R3 three carries", time_ns, 24);
    repeat (5) @(negedge clk);
    chk(time_ns == 24, "R2 frozen", time_ns, 24);
    rd(4'd4, 32'hC000_0000, "R3 accumulator phase");
    rd(4'd1, 32'd24, "R3 count read");

    // R4 bypass, R5 write wins over a same-cycle step
    wr(4'd0, SRST | PER10);
    wr(4'd4, 32'h1234_5678);
    wr(4'd1, 32'h100);
    wr(4'd0, EN | BYP | PER10);
    repeat (4) @(negedge clk);
    wr(4'd2, 32'h0);
    repeat (2) @(negedge clk);
    wr(4'd0, PER10);
    chk(time_ns == 64'd286, "R5 write wins over step", time_ns, 64'd286);
    rd(4'd4, 32'h1234_5678, "R4 accumulator held");

    // R7 R9 R10: realigned pulses
    wr(4'd0, SRST | PER10);
    wr(4'd10, 32'd300);
    wr(4'd11, 32'd250);
    wr(4'd6, 32'd990);
    wr(4'd7, 32'd0);
    wr(4'd8, 32'd1500);
    wr(4'd9, 32'd0);
    clear_mon();
    wr(4'd0, EN | BYP | PER10);
    repeat (179) @(negedge clk);
    wr(4'd0, PER10);
    @(negedge clk);
    chk(time_ns == 64'd1800, "R4 bypass steps", time_ns, 64'd1800);
    chk(a0_t == 64'd1000, "R7 alarm0 time", a0_t, 64'd1000);
    chk(a1_t == 64'd1510, "R7 alarm1 time", a1_t, 64'd1510);
    chk(a0_out == 1'b1, "R8 pin follows strobe", a0_out, 1);
    chk(pre_n == 0, "R10 no pulse before alarm0", pre_n, 0);
    chk(p_first[0] == 64'd1300, "R10 gen0 first", p_first[0], 64'd1300);
    chk(p_n[0] == 2, "R9 gen0 count", p_n[0], 2);
    chk(p_first[1] == 64'd1250, "R10 gen1 first", p_first[1], 64'd1250);
    chk(p_n[1] == 3, "R9 gen1 count", p_n[1], 3);
    rd(4'd0, PER10 | 32'h1000_0000, "R10 started flag");

    // R8 polarity
    wr(4'd0, 32'h8000_0000 | PER10);
    repeat (2) @(negedge clk);
    chk(alarm_out == 2'b01, "R8 inverted pin", alarm_out, 2'b01);

    // R11 realignment disabled, R12 clears started
    wr(4'd0, SRST | PER10);
    rd(4'd0, PER10, "R12 started cleared");
    clear_mon();
    wr(4'd0, EN | BYP | NOAL | PER10);
    repeat (139) @(negedge clk);
    wr(4'd0, PER10);
    @(negedge clk);
    chk(alarm_out == 2'b00, "R8 polarity restored", alarm_out, 0);
    chk(p_first[0] == 64'd300, "R11 gen0 free start", p_first[0], 64'd300);
    chk(p_last[0] == 64'd1200, "R11 gen0 not rephased", p_last[0], 64'd1200);
    chk(p_n[0] == 4, "R11 gen0 count", p_n[0], 4);
    chk(p_n[1] == 5, "R9 gen1 free count", p_n[1], 5);
    chk(a0_t == 64'd1000, "R7 alarm0 again", a0_t, 64'd1000);

    // R13 prescaler, R14 readback
    wr(4'd0, SRST | PER10);
    wr(4'd5, 32'd3);
    repeat (2) @(negedge clk);
    tog_n = 0;
    wr(4'd0, EN | BYP | PER10);
    repeat (29) @(negedge clk);
    wr(4'd0, PER10);
    repeat (2) @(negedge clk);
    chk(tog_n == 10, "R13 toggles", tog_n, 10);
    rd(4'd5, 32'd3, "R14 prescale");
    rd(4'd10, 32'd300, "R14 period0");
    rd(4'd11, 32'd250, "R14 period1");
    rd(4'd8, 32'd1500, "R14 alarm1 low");
    rd(4'd7, 32'd0, "R14 alarm0 high");
    wr(4'd0, 32'h4000_0003 | NOAL | PER8);
    rd(4'd0, 32'h4000_0003 | NOAL | PER8, "R14 control fields");

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule